// File: doc/BRIEF.md
# Overrange Detection and Output Clamp

This block sits between a decimation filter and the output word register of a sigma-delta converter. Each filtered word arrives wider than the output word. When the word fits the signed output range, the block passes it through. When it does not fit, the block clips it to the full-scale code that matches the sign of the overflow. It also drops a data-valid flag for that word.

A second and more severe condition comes in on a one-cycle pulse, which stands for a modulator instability detector outside this block. The pulse opens a recovery window of fixed length. During the window every word leaves as negative full scale and data-valid stays low. Data-ready keeps pulsing for each word. A further pulse inside the window starts the window again from its full length.

The data-valid output shares a pin with a sync input. A control bit chooses the role of the pin. In the sync role the data-valid driver is disabled, and rising edges on the pin become a one-cycle sync strobe. A sticky overrange bit records every overload and every instability pulse in both roles, and it holds until it is cleared.

Top module: `ovr_clamp_top`

## Requirements
- R1: While reset is asserted and in the cycle after it is released: word_o is 0, word_rdy_o is 0, dval_o is 1, sync_o is 0 and sticky_ovr_o is 0.
- R2: For an input word inside the signed OUT_W-bit range, word_o equals its low OUT_W bits. word_rdy_o is 1 for exactly the one cycle after the word_valid_i cycle. dval_o is 1 in that cycle.
- R3: For an input word above the largest positive output value, word_o is 0x7FFF (with OUT_W=16) and dval_o is 0.
- R4: For an input word below the most negative output value, word_o is 0x8000 (with OUT_W=16) and dval_o is 0.
- R5: An unstable_i pulse holds dval_o low for exactly RECOVER_CYC cycles, counted from the cycle after the pulse.
- R6: A word accepted in the pulse cycle or inside the window leaves as 0x8000, whatever its value, and word_rdy_o still pulses for it. An instability pulse takes precedence over a positive overload in the same cycle.
- R7: A new unstable_i pulse inside an active window restarts the full RECOVER_CYC count.
- R8: With pin_role_i=0 (data-valid role), dval_oe_o is 1 and sync_o stays 0. With pin_role_i=1 (sync role), dval_oe_o is 0, and a rising edge on pin_sync_i gives sync_o=1 for exactly the next cycle.
- R9: sticky_ovr_o is set by an overloaded word or an unstable_i pulse in either pin role. It holds until sticky_clr_i is applied, and a set in the same cycle as a clear wins.
- R10: Outside a window, dval_o follows the most recent word: it returns to 1 after an in-range word that follows an overload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid_i | input | 1 | Filter word strobe |
| word_raw_i | input | IN_W | Wide two's-complement filter word |
| unstable_i | input | 1 | Instability detected pulse |
| pin_role_i | input | 1 | Shared pin role: 0 data-valid, 1 sync |
| pin_sync_i | input | 1 | Shared pin level when it is used as sync input |
| sticky_clr_i | input | 1 | Clear for the sticky overrange bit |
| word_o | output | OUT_W | Clamped output word |
| word_rdy_o | output | 1 | New word strobe |
| dval_o | output | 1 | Data-valid flag |
| dval_oe_o | output | 1 | Output enable of the data-valid driver |
| sync_o | output | 1 | Sync strobe on a rising pin edge |
| sticky_ovr_o | output | 1 | Sticky overrange status |

## Verification
The critical collision is an overloaded word that arrives in the same cycle as an instability pulse. Two paths then compete for the output word: the sign-dependent clip, and the forced negative full scale. The bench drives a positive-overflow word together with unstable_i. It expects 0x8000, not 0x7FFF, and it expects dval_o low for the whole recovery window that follows. A second collision applies sticky_clr_i in the same cycle as an overload, and the bench checks that the sticky bit stays set.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
   typedef enum logic {
      ROLE_DVAL = 1'b0,
      ROLE_SYNC = 1'b1
   } pin_role_e;
endpackage

// File: rtl/ovr_sat.sv
module ovr_sat #(
   parameter int IN_W  = 24,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  raw_i,
   output logic [OUT_W-1:0] word_o,
   output logic             pos_o,
   output logic             neg_o
);
   localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

   generate
      if (IN_W > OUT_W) begin : g_wide
         localparam int HI_W = IN_W - OUT_W + 1;
         logic [HI_W-1:0] hi_bits;
         logic            agree;
         assign hi_bits = raw_i[IN_W-1:OUT_W-1];
         assign agree   = (&hi_bits) | ~(|hi_bits);
         assign pos_o   = ~agree & ~raw_i[IN_W-1];
         assign neg_o   = ~agree &  raw_i[IN_W-1];
         always_comb begin
            if (pos_o)      word_o = POS_FS;
            else if (neg_o) word_o = NEG_FS;
            else            word_o = raw_i[OUT_W-1:0];
         end
      end else begin : g_equal
         assign pos_o  = 1'b0;
         assign neg_o  = 1'b0;
         assign word_o = raw_i[OUT_W-1:0];
      end
   endgenerate

   always_comb begin
      assert (!(pos_o && neg_o)) else $error("AST_SAT_EXCL"); // R3
   end
endmodule

// File: rtl/ovr_recovery_timer.sv
module ovr_recovery_timer #(
   parameter int RECOVER_CYC = 2080
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);
   localparam int CNT_W = $clog2(RECOVER_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(RECOVER_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active_o = (cnt_q != '0);

   AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> cnt_q == LOAD); // R7
   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
   AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && cnt_q == '0) |=> cnt_q == '0); // R5
endmodule

// File: rtl/ovr_pin_role.sv
module ovr_pin_role
   import ovr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic role_i,
   input  logic pin_i,
   output logic oe_o,
   output logic sync_o
);
   pin_role_e role;
   logic      pin_q;
   logic      sync_q;

   assign role = pin_role_e'(role_i);
   assign oe_o = (role == ROLE_DVAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         sync_q <= 1'b0;
      end else begin
         pin_q  <= pin_i;
         sync_q <= (role == ROLE_SYNC) & pin_i & ~pin_q;
      end
   end

   assign sync_o = sync_q;

   AST_SYNC_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |-> $past(role_i) && $past(pin_i)); // R8
   AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o); // R8
endmodule

// File: rtl/ovr_clamp_top.sv
module ovr_clamp_top #(
   parameter int IN_W        = 24,
   parameter int OUT_W       = 16,
   parameter int RECOVER_CYC = 2080
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_valid_i,
   input  logic [IN_W-1:0]  word_raw_i,
   input  logic             unstable_i,
   input  logic             pin_role_i,
   input  logic             pin_sync_i,
   input  logic             sticky_clr_i,
   output logic [OUT_W-1:0] word_o,
   output logic             word_rdy_o,
   output logic             dval_o,
   output logic             dval_oe_o,
   output logic             sync_o,
   output logic             sticky_ovr_o
);
   localparam logic [OUT_W-1:0] POS_FS = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] NEG_FS = {1'b1, {(OUT_W-1){1'b0}}};

   initial begin
      assert (IN_W >= OUT_W) else $fatal(1, "IN_W must not be below OUT_W");
      assert (OUT_W >= 2)    else $fatal(1, "OUT_W too small");
      assert (RECOVER_CYC >= 1) else $fatal(1, "RECOVER_CYC must be positive");
   end

   logic [OUT_W-1:0] sat_word;
   logic             sat_pos, sat_neg;
   logic             win_active;
   logic             forced;
   logic             word_bad;

   logic [OUT_W-1:0] word_q;
   logic             rdy_q, dval_q, sticky_q;

   ovr_sat #(.IN_W(IN_W), .OUT_W(OUT_W)) i_sat (
      .raw_i  (word_raw_i),
      .word_o (sat_word),
      .pos_o  (sat_pos),
      .neg_o  (sat_neg)
   );

   ovr_recovery_timer #(.RECOVER_CYC(RECOVER_CYC)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (unstable_i),
      .active_o (win_active)
   );

   ovr_pin_role i_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .role_i (pin_role_i),
      .pin_i  (pin_sync_i),
      .oe_o   (dval_oe_o),
      .sync_o (sync_o)
   );

   assign forced   = unstable_i | win_active;
   assign word_bad = sat_pos | sat_neg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q   <= '0;
         rdy_q    <= 1'b0;
         dval_q   <= 1'b1;
         sticky_q <= 1'b0;
      end else begin
         rdy_q <= word_valid_i;
         if (word_valid_i) begin
            word_q <= forced ? NEG_FS : sat_word;
            dval_q <= ~(forced | word_bad);
         end
         sticky_q <= (sticky_q & ~sticky_clr_i)
                   | (word_valid_i & word_bad) | unstable_i;
      end
   end

   assign word_o       = word_q;
   assign word_rdy_o   = rdy_q;
   assign dval_o       = dval_q & ~win_active;
   assign sticky_ovr_o = sticky_q;

   AST_RDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_rdy_o == $past(word_valid_i)); // R2
   AST_FORCED_NEG: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_i && forced) |=> word_o == NEG_FS && !dval_o); // R6
   AST_POS_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_i && !forced && sat_pos) |=> word_o == POS_FS && !dval_o); // R3
   AST_NEG_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_i && !forced && sat_neg) |=> word_o == NEG_FS && !dval_o); // R4
   AST_WIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      unstable_i |=> !dval_o); // R5
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_ovr_o && !sticky_clr_i) |=> sticky_ovr_o); // R9
endmodule

// File: tb/test_ovr_clamp_top.sv
module test_ovr_clamp_top;
   localparam int IN_W = 24;
   localparam int OUT_W = 16;
   localparam int RECOVER_CYC = 2080;

   logic clk = 1'b0;
   logic rst_n;
   logic word_valid_i;
   logic [IN_W-1:0] word_raw_i;
   logic unstable_i, pin_role_i, pin_sync_i, sticky_clr_i;
   logic [OUT_W-1:0] word_o;
   logic word_rdy_o, dval_o, dval_oe_o, sync_o, sticky_ovr_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ovr_clamp_top #(.IN_W(IN_W), .OUT_W(OUT_W), .RECOVER_CYC(RECOVER_CYC)) i_ovr_clamp_top (
      .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid_i), .word_raw_i(word_raw_i),
      .unstable_i(unstable_i), .pin_role_i(pin_role_i), .pin_sync_i(pin_sync_i),
      .sticky_clr_i(sticky_clr_i), .word_o(word_o), .word_rdy_o(word_rdy_o),
      .dval_o(dval_o), .dval_oe_o(dval_oe_o), .sync_o(sync_o), .sticky_ovr_o(sticky_ovr_o)
   );

   task automatic check(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic longint exp_word(longint v);
      if (v > 32767)       return 64'h7FFF;
      else if (v < -32768) return 64'h8000;
      else                 return v & 64'hFFFF;
   endfunction

   function automatic logic exp_dval(longint v);
      return (v <= 32767) && (v >= -32768);
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send(longint v, logic unst, output logic [OUT_W-1:0] w, output logic dv,
                       output logic rdy);
      word_valid_i = 1'b1;
      word_raw_i   = v[IN_W-1:0];
      unstable_i   = unst;
      tick();
      word_valid_i = 1'b0;
      unstable_i   = 1'b0;
      w = word_o; dv = dval_o; rdy = word_rdy_o;
   endtask

   task automatic send_chk(string req, longint v);
      logic [OUT_W-1:0] w; logic dv, rdy;
      send(v, 1'b0, w, dv, rdy);
      check({req, " word"}, w, exp_word(v));
      check({req, " dval"}, dv, exp_dval(v));
      check({req, " rdy"}, rdy, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [OUT_W-1:0] w; logic dv, rdy;
      void'($urandom(32'd4242));
      rst_n = 1'b0; word_valid_i = 1'b0; word_raw_i = '0; unstable_i = 1'b0;
      pin_role_i = 1'b0; pin_sync_i = 1'b0; sticky_clr_i = 1'b0;
      repeat (3) tick();
      // R1 reset state
      check("R1 word", word_o, 0);
      check("R1 rdy", word_rdy_o, 0);
      check("R1 dval", dval_o, 1);
      check("R1 sticky", sticky_ovr_o, 0);
      check("R1 sync", sync_o, 0);
      rst_n = 1'b1;
      tick();
      check("R1 after release dval", dval_o, 1);
      check("R1 after release rdy", word_rdy_o, 0);

      // R2 in-range, rdy single pulse
      send_chk("R2", 1234);
      send_chk("R2", -1);
      send_chk("R2", 32767);
      send_chk("R2", -32768);
      tick();
      check("R2 rdy drops", word_rdy_o, 0);

      // R3 / R4 / R10 directed boundaries
      send_chk("R3", 32768);
      send_chk("R10", 5);
      send_chk("R4", -32769);
      send_chk("R10", -7);
      send_chk("R3", 64'sd8388607);
      send_chk("R4", -64'sd8388608);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         longint v;
         int unsigned r = $urandom;
         case (r % 4)
            0: v = longint'($urandom % 65536) - 32768;
            1: v = 32768 + longint'($urandom % (8388608 - 32768));
            2: v = -32769 - longint'($urandom % (8388608 - 32769));
            default: case ($urandom % 4)
               0: v = 32767; 1: v = 32768; 2: v = -32768; default: v = -32769;
            endcase
         endcase
         send_chk("R2 R3 R4 random", v);
      end
      send_chk("R10", 100);

      // R5 window length
      unstable_i = 1'b1;
      tick();
      unstable_i = 1'b0;
      check("R5 first", dval_o, 0);
      repeat (RECOVER_CYC - 1) tick();
      check("R5 last", dval_o, 0);
      tick();
      check("R5 end", dval_o, 1);

      // R7 restart
      unstable_i = 1'b1; tick(); unstable_i = 1'b0;
      repeat (1000) tick();
      unstable_i = 1'b1; tick(); unstable_i = 1'b0;
      repeat (1500) tick();
      check("R7 still low", dval_o, 0);
      repeat (RECOVER_CYC - 1 - 1500) tick();
      check("R7 last", dval_o, 0);
      tick();
      check("R7 end", dval_o, 1);

      // R6 collision: positive overload with pulse, then words inside window
      send(64'sd100000, 1'b1, w, dv, rdy);
      check("R6 collision word", w, 64'h8000);
      check("R6 collision dval", dv, 0);
      check("R6 collision rdy", rdy, 1);
      send(64'sd42, 1'b0, w, dv, rdy);
      check("R6 window word", w, 64'h8000);
      check("R6 window rdy", rdy, 1);
      repeat (RECOVER_CYC) tick();
      check("R6 holds after window", dval_o, 0);
      send_chk("R10", 42);

      // R9 sticky
      sticky_clr_i = 1'b1; tick(); sticky_clr_i = 1'b0;
      check("R9 cleared", sticky_ovr_o, 0);
      send_chk("R9 set", 40000);
      check("R9 set", sticky_ovr_o, 1);
      send_chk("R9 held", 1);
      check("R9 held", sticky_ovr_o, 1);
      sticky_clr_i = 1'b1; send(-40000, 1'b0, w, dv, rdy); sticky_clr_i = 1'b0;
      check("R9 set wins", sticky_ovr_o, 1);
      sticky_clr_i = 1'b1; tick(); sticky_clr_i = 1'b0;
      check("R9 clear", sticky_ovr_o, 0);

      // R8 data-valid role ignores pin edges
      check("R8 oe dval role", dval_oe_o, 1);
      pin_sync_i = 1'b1; tick();
      check("R8 no sync in dval role", sync_o, 0);
      pin_sync_i = 1'b0; tick();
      // R8 sync role
      pin_role_i = 1'b1; tick();
      check("R8 oe sync role", dval_oe_o, 0);
      pin_sync_i = 1'b1; tick();
      check("R8 sync pulse", sync_o, 1);
      tick();
      check("R8 sync single", sync_o, 0);
      pin_sync_i = 1'b0;
      send(-50000, 1'b0, w, dv, rdy);
      check("R9 sticky in sync role", sticky_ovr_o, 1);
      check("R8 oe stays off", dval_oe_o, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule